// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is a register-mapped serial peripheral master. Software sets a baud divisor and a control word, then queues up to eight transmit words. The controller shifts each word out on `mosi` with the configured clock polarity, clock phase, bit order and word length (1 to 16 bits). For every word sent it shifts one word in, from `miso` or, in loopback, from its own `mosi`. Each word it receives goes into an eight-entry receive queue, right-justified.

A level interrupt reports that every queued transmit word has left the shift engine, so a driver can refill the transmit queue and drain the receive queue in bursts. A soft-reset bit in the control word holds the queues, the shift engine and the clock divider in reset. It does not touch the stored configuration.

Top module: `spim_master`

## Requirements
- R1: After reset, the divisor, control and interrupt-enable registers read 0, and `sclk`, `mosi` and `irq` are all low.
- R2: The registers have these offsets: divisor 0x00 (read/write), transmit data 0x04 (write pushes, read gives 0), receive data 0x08, control 0x0C (read/write, all 16 bits), interrupt enable 0x10 (only bit 2 is kept and read back) and 0x18 (accepts writes, reads 0).
- R3: Control bits [3:0] hold the word length minus one. A word of N bits gives exactly N sampling edges of `sclk`. The received word is right-justified and its bits above N-1 are 0.
- R4: When control bit 4 is 1, bit N-1 is sent first; when it is 0, bit 0 is sent first. Received bits are placed in the same order.
- R5: Control bit 6 sets the idle level of `sclk`. With control bit 5 at 0, data is sampled on the leading edge of each clock pulse; with it at 1, data is sampled on the trailing edge.
- R6: When control bit 10 is 1, the receive path takes the outgoing `mosi` bit and ignores `miso`. When it is 0, the receive path takes `miso`.
- R7: Each `sclk` half-period lasts exactly D input clock cycles, where D is the divisor. A divisor of 0 acts as 65536.
- R8: With control bit 11 set, the transmit queue holds 8 words, and a write to it while it is full is dropped. With bit 11 clear, the queue holds one word.
- R9: With control bit 12 set, the receive queue holds 8 words, and a word that arrives while the queue is full is dropped. With bit 12 clear, the queue holds one word. Reading offset 0x08 pops one entry and returns 0 when the queue is empty.
- R10: A word starts shifting only while control bit 9 (enable) and bit 8 (master) are both 1 and bit 7 is 0.
- R11: `irq` is high exactly when interrupt-enable bit 2 is 1, the transmit queue is empty and no word is shifting.
- R12: While control bit 7 is 1, both queues are emptied, any word in progress is abandoned and `sclk` returns to its idle level. The divisor, control and interrupt-enable values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x08) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transmit-idle interrupt level |

## Verification
A register write takes effect at the clock edge that samples it. A queued word starts shifting at the following edge. In phase-1 mode the first `sclk` edge appears at that start; in phase-0 mode it appears D cycles later. Every further edge follows D cycles after the one before. `irq` and the new receive entry both appear right after the edge that ends the final half-period. The bench therefore waits for `irq` at falling clock edges before it reads the receive data. It timestamps every `sclk` edge, so it checks each gap against D. It allows one extra cycle after a soft-reset write before it checks the idle clock level.

// File: rtl/spim_pkg.sv
// Shared constants for the SPI master: register offsets and control-word
// bit positions. Assumes a 16-bit register data path.
package spim_pkg;
    localparam int REG_W = 16;

    localparam logic [4:0] A_BAUD = 5'h00;
    localparam logic [4:0] A_TXD  = 5'h04;
    localparam logic [4:0] A_RXD  = 5'h08;
    localparam logic [4:0] A_CTRL = 5'h0C;
    localparam logic [4:0] A_IEN  = 5'h10;
    localparam logic [4:0] A_AUX  = 5'h18;

    localparam int C_MSB  = 4;
    localparam int C_CPHA = 5;
    localparam int C_CPOL = 6;
    localparam int C_SRST = 7;
    localparam int C_MAST = 8;
    localparam int C_EN   = 9;
    localparam int C_LOOP = 10;
    localparam int C_TXFE = 11;
    localparam int C_RXFE = 12;

    localparam int IEN_TXIDLE = 2;
endpackage

// File: rtl/spim_fifo.sv
// Synchronous queue with a depth limit that can be selected at run time.
// With 'single' high it accepts only one entry. Pushes while full and pops
// while empty are ignored. 'clr' empties it and takes priority.
// Assumes DEPTH >= 2.
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = single ? (count != '0) : (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end
endmodule

// File: rtl/spim_clkdiv.sv
// Half-period tick generator. While 'run' is high it pulses 'tick' once
// every 'div' cycles. A 'div' of zero gives 2**DIVW cycles, because the
// terminal count wraps. When 'run' is low the count is held at zero.
module spim_clkdiv #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;

    assign lim  = div - 1'b1;
    assign tick = run && (cnt == lim);

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spim_shifter.sv
// Serial shift engine. It loads one word, then steps through 2*N
// half-periods on 'tick'. It samples the input on every even-to-odd step
// and reports the assembled word on the final step. Assumes the
// configuration inputs are stable while a word is shifting.
module spim_shifter #(
    parameter int DW = 16,
    parameter int LW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          start_ok,
    input  logic          tx_avail,
    input  logic [DW-1:0] tx_word,
    output logic          tx_pop,
    input  logic          tick,
    input  logic [LW-1:0] len_m1,
    input  logic          msb_first,
    input  logic          cpha,
    input  logic          cpol,
    input  logic          loop_en,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          rx_push,
    output logic [DW-1:0] rx_word
);
    logic [LW:0]   half;
    logic [DW-1:0] shreg, acc;
    logic [LW-1:0] k, idx;
    logic          last, sin;

    assign k       = half[LW:1];
    assign idx     = msb_first ? (len_m1 - k) : k;
    assign last    = (half == {len_m1, 1'b1});
    assign tx_pop  = !busy && start_ok && tx_avail && !clr;
    assign mosi    = busy ? shreg[idx] : 1'b0;
    assign sin     = loop_en ? mosi : miso;
    assign sclk    = busy ? (cpol ^ (cpha ? ~half[0] : half[0])) : cpol;
    assign rx_push = busy && tick && last;
    assign rx_word = acc;

    // Word load, half-period stepping and input sampling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy  <= 1'b0;
            half  <= '0;
            shreg <= '0;
            acc   <= '0;
        end else if (tx_pop) begin
            busy  <= 1'b1;
            half  <= '0;
            shreg <= tx_word;
            acc   <= '0;
        end else if (busy && tick) begin
            if (!half[0]) acc[idx] <= sin;
            if (last) begin
                busy <= 1'b0;
                half <= '0;
            end else begin
                half <= half + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spim_master.sv
// SPI master top. It holds the divisor, control and interrupt-enable
// registers, the transmit and receive queues, the divider and the shift
// engine. It assumes DW <= 16 and DIVW <= 16, and that reads have no side
// effects except at the receive-data offset.
module spim_master
    import spim_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int DIVW  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             irq
);
    localparam int LW = $clog2(DW);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DIVW-1:0]  baud_q;
    logic [REG_W-1:0] ctl_q;
    logic             ien_q;

    logic          srst, cpol, ctl_wr, tx_push, rx_pop;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [DW-1:0] tx_dout, rx_dout, rx_word;
    logic          tx_pop, rx_push, busy, tick;

    assign srst    = ctl_q[C_SRST];
    assign cpol    = ctl_q[C_CPOL];
    assign ctl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign tx_push = reg_wr && (reg_addr == A_TXD);
    assign rx_pop  = reg_rd && (reg_addr == A_RXD);
    assign irq     = ien_q && tx_empty && !busy;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_q <= '0;
            ctl_q  <= '0;
            ien_q  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_BAUD:  baud_q <= reg_wdata[DIVW-1:0];
                A_CTRL:  ctl_q  <= reg_wdata;
                A_IEN:   ien_q  <= reg_wdata[IEN_TXIDLE];
                default: ;
            endcase
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_BAUD:  reg_rdata = REG_W'(baud_q);
            A_CTRL:  reg_rdata = ctl_q;
            A_IEN:   reg_rdata = REG_W'(ien_q) << IEN_TXIDLE;
            A_RXD:   reg_rdata = rx_empty ? '0 : REG_W'(rx_dout);
            default: reg_rdata = '0;
        endcase
    end

    spim_fifo #(.W(DW), .DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(srst), .single(!ctl_q[C_TXFE]),
        .push(tx_push), .din(reg_wdata[DW-1:0]), .pop(tx_pop),
        .dout(tx_dout), .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    spim_fifo #(.W(DW), .DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(srst), .single(!ctl_q[C_RXFE]),
        .push(rx_push), .din(rx_word), .pop(rx_pop),
        .dout(rx_dout), .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    spim_clkdiv #(.DIVW(DIVW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy && !srst), .div(baud_q), .tick(tick)
    );

    spim_shifter #(.DW(DW), .LW(LW)) u_shf (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .start_ok(ctl_q[C_EN] && ctl_q[C_MAST]),
        .tx_avail(!tx_empty), .tx_word(tx_dout), .tx_pop(tx_pop),
        .tick(tick), .len_m1(ctl_q[LW-1:0]), .msb_first(ctl_q[C_MSB]),
        .cpha(ctl_q[C_CPHA]), .cpol(cpol), .loop_en(ctl_q[C_LOOP]),
        .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy),
        .rx_push(rx_push), .rx_word(rx_word)
    );
endmodule

// File: rtl/spim_checker.sv
// Property checker for spim_master, attached through bind. It watches the
// serial clock level, the queue occupancy bounds, soft reset and the
// interrupt condition.
module spim_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclk,
    input logic          cpol,
    input logic          busy,
    input logic          tick,
    input logic          srst,
    input logic          ctl_wr,
    input logic          irq,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);
    // R5: the clock rests at the polarity level whenever nothing shifts
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R7: the clock only moves on a divider tick
    a_r7_sclk_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !srst && !ctl_wr) |=> $stable(sclk));

    // R8: transmit occupancy never exceeds the depth
    a_r8_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));

    // R9: receive occupancy never exceeds the depth
    a_r9_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    // R12: soft reset empties both queues and stops the engine
    a_r12_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && tx_cnt == '0 && rx_cnt == '0));

    // R11: interrupt only with nothing queued and nothing shifting
    a_r11_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tx_cnt == '0 && !busy));
endmodule

bind spim_master spim_checker #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cpol(cpol), .busy(busy),
    .tick(tick), .srst(srst), .ctl_wr(ctl_wr), .irq(irq),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sim_spim_master.sv
`timescale 1ns/1ps
module sim_spim_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sclk, mosi, miso, irq;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;
    assign miso = ~mosi;

    spim_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
    );

    // Serial monitor: edge count, sample-edge data capture and edge gaps.
    logic        mon_on = 1'b0;
    logic        cpol_b = 1'b0, cpha_b = 1'b0;
    int          n_edges = 0, n_smp = 0;
    logic [31:0] seq = '0;
    time         last_t = 0;
    int          exp_gap = 7;
    logic        gap_bad = 1'b0;
    time         gap_last = 0;

    always @(sclk) begin
        if (mon_on) begin
            if (n_edges > 0) begin
                gap_last = $time - last_t;
                if (gap_last != time'(exp_gap) * 4) gap_bad = 1'b1;
            end
            last_t = $time;
            n_edges = n_edges + 1;
            if (sclk === (cpol_b ^ ~cpha_b)) begin
                if (n_smp < 32) seq[n_smp] = mosi;
                n_smp = n_smp + 1;
            end
        end
    end

    task automatic mon_start();
        n_edges = 0; n_smp = 0; seq = '0; gap_bad = 1'b0; gap_last = 0;
        mon_on = 1'b1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq();
        while (irq !== 1'b1) @(negedge clk);
    endtask

    function automatic logic [15:0] ctlw(input int wl, input bit msb, input bit ph,
                                         input bit po, input bit lp, input bit en,
                                         input bit ms, input bit tfe, input bit rfe);
        return 16'(wl - 1) | (16'(msb) << 4) | (16'(ph) << 5) | (16'(po) << 6) |
               (16'(ms) << 8) | (16'(en) << 9) | (16'(lp) << 10) |
               (16'(tfe) << 11) | (16'(rfe) << 12);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (199000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [15:0] v, w, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); check("R1 baud", v, 0);
        rd(5'h0C, v); check("R1 ctrl", v, 0);
        rd(5'h10, v); check("R1 ien", v, 0);
        check("R1 irq", irq, 0);
        check("R1 sclk", sclk, 0);
        check("R1 mosi", mosi, 0);

        // R2 register map
        wr(5'h00, 16'h1234); rd(5'h00, v); check("R2 baud rw", v, 16'h1234);
        wr(5'h0C, 16'h00A5); rd(5'h0C, v); check("R2 ctrl rw", v, 16'h00A5);
        wr(5'h10, 16'hFFFF); rd(5'h10, v); check("R2 ien bit2 only", v, 16'h0004);
        rd(5'h04, v); check("R2 txd reads 0", v, 0);
        wr(5'h18, 16'h0000); rd(5'h18, v); check("R2 aux reads 0", v, 0);
        wr(5'h0C, 16'h0000);

        // R11 interrupt enable gating
        wr(5'h10, 16'h0000); check("R11 irq off when disabled", irq, 0);
        wr(5'h10, 16'h0004); check("R11 irq on when idle", irq, 1);

        // R3 R4 R5 R6 R7: sweep of length, mode and order over the miso path
        wr(5'h00, 16'd7); exp_gap = 7;
        for (int wl = 1; wl <= 16; wl++) begin
            for (int md = 0; md < 4; md++) begin
                for (int od = 0; od < 2; od++) begin
                    logic ok;
                    cpol_b = md[1]; cpha_b = md[0];
                    m = 16'((32'h1 << wl) - 1);
                    w = 16'(16'hA5C3 ^ (wl * 16'h1357) ^ (md * 16'h0F0F) ^ (od * 16'h3333)) & m;
                    mon_on = 1'b0;
                    wr(5'h0C, ctlw(wl, od[0], md[0], md[1], 0, 1, 1, 1, 1));
                    mon_start();
                    wr(5'h04, w);
                    wait_irq();
                    mon_on = 1'b0;
                    rd(5'h08, v);
                    check("R6 miso path R3 right-justified", v, ~w & m);
                    check("R3 sample edges", n_smp, wl);
                    ok = 1'b1;
                    for (int j = 0; j < wl; j++)
                        if (seq[j] !== (od ? w[wl-1-j] : w[j])) ok = 1'b0;
                    check("R4 R5 bit order and phase", ok, 1);
                    check("R5 idle level", sclk, md[1]);
                    check("R7 half period 7", gap_bad, 0);
                end
            end
        end
        cpol_b = 0; cpha_b = 0;

        // R6 loopback ignores miso
        wr(5'h0C, ctlw(16, 1, 0, 0, 1, 1, 1, 1, 1));
        wr(5'h04, 16'hBEEF); wait_irq(); rd(5'h08, v);
        check("R6 loopback 16b", v, 16'hBEEF);
        wr(5'h0C, ctlw(5, 0, 1, 1, 1, 1, 1, 1, 1));
        wr(5'h04, 16'h0016); wait_irq(); rd(5'h08, v);
        check("R6 loopback 5b", v, 16'h0016);

        // R8 transmit depth: nine writes while disabled, eight survive
        wr(5'h0C, ctlw(8, 1, 0, 0, 1, 0, 1, 1, 1));
        for (int i = 0; i < 9; i++) wr(5'h04, 16'(8'h10 + i));
        check("R8 irq low while queued", irq, 0);
        wr(5'h0C, ctlw(8, 1, 0, 0, 1, 1, 1, 1, 1));
        wait_irq();
        for (int i = 0; i < 8; i++) begin
            rd(5'h08, v); check("R8 queued word", v, 16'(8'h10 + i));
        end
        rd(5'h08, v); check("R8 ninth write dropped", v, 0);

        // R8 single-entry transmit queue
        wr(5'h0C, ctlw(8, 1, 0, 0, 1, 0, 1, 0, 1));
        wr(5'h04, 16'h0055); wr(5'h04, 16'h0066);
        wr(5'h0C, ctlw(8, 1, 0, 0, 1, 1, 1, 0, 1));
        wait_irq();
        rd(5'h08, v); check("R8 single tx first", v, 16'h0055);
        rd(5'h08, v); check("R8 single tx second dropped", v, 0);

        // R9 receive depth: overflow words dropped
        wr(5'h0C, ctlw(8, 0, 0, 0, 1, 1, 1, 1, 1));
        for (int i = 0; i < 8; i++) wr(5'h04, 16'(8'h40 + i));
        wait_irq();
        for (int i = 0; i < 3; i++) wr(5'h04, 16'(8'hC0 + i));
        wait_irq();
        for (int i = 0; i < 8; i++) begin
            rd(5'h08, v); check("R9 rx kept oldest", v, 16'(8'h40 + i));
        end
        rd(5'h08, v); check("R9 rx empty reads 0", v, 0);

        // R9 single-entry receive queue
        wr(5'h0C, ctlw(8, 0, 0, 0, 1, 1, 1, 1, 0));
        wr(5'h04, 16'h0071); wr(5'h04, 16'h0072); wr(5'h04, 16'h0073);
        wait_irq();
        rd(5'h08, v); check("R9 single rx first", v, 16'h0071);
        rd(5'h08, v); check("R9 single rx rest dropped", v, 0);

        // R10 no shifting without master mode
        wr(5'h0C, ctlw(4, 1, 0, 0, 1, 1, 0, 1, 1));
        mon_start();
        wr(5'h04, 16'h0009);
        repeat (200) @(negedge clk);
        check("R10 no edges without master", n_edges, 0);
        check("R10 irq low while held", irq, 0);
        wr(5'h0C, ctlw(4, 1, 0, 0, 1, 1, 1, 1, 1));
        wait_irq(); mon_on = 1'b0;
        check("R10 starts in master mode", n_edges, 8);
        rd(5'h08, v); check("R10 word after start", v, 16'h0009);

        // R12 soft reset drops queued words, keeps configuration
        wr(5'h0C, ctlw(8, 1, 0, 0, 1, 0, 1, 1, 1));
        wr(5'h04, 16'h0011); wr(5'h04, 16'h0022); wr(5'h04, 16'h0033);
        wr(5'h0C, ctlw(8, 1, 0, 0, 1, 1, 1, 1, 1) | 16'h0080);
        repeat (3) @(negedge clk);
        mon_start();
        wr(5'h0C, ctlw(8, 1, 0, 0, 1, 1, 1, 1, 1));
        check("R12 tx emptied irq high", irq, 1);
        repeat (50) @(negedge clk);
        mon_on = 1'b0;
        check("R12 nothing shifted", n_edges, 0);
        rd(5'h08, v); check("R12 rx empty", v, 0);
        rd(5'h00, v); check("R12 baud kept", v, 16'd7);
        rd(5'h10, v); check("R12 ien kept", v, 16'h0004);

        // R12 soft reset mid-word returns clock to idle
        wr(5'h00, 16'd50);
        wr(5'h0C, ctlw(16, 1, 0, 1, 1, 1, 1, 1, 1));
        wr(5'h04, 16'h5A5A);
        repeat (120) @(negedge clk);
        wr(5'h0C, ctlw(16, 1, 0, 1, 1, 1, 1, 1, 1) | 16'h0080);
        @(negedge clk);
        check("R12 sclk idle after abort", sclk, 1);
        wr(5'h0C, ctlw(16, 1, 0, 1, 1, 1, 1, 1, 1));
        check("R12 irq after abort", irq, 1);
        rd(5'h08, v); check("R12 no word after abort", v, 0);

        // R7 other divisors
        wr(5'h00, 16'd12); exp_gap = 12;
        wr(5'h0C, ctlw(3, 1, 0, 0, 1, 1, 1, 1, 1));
        mon_start(); wr(5'h04, 16'h0005); wait_irq(); mon_on = 1'b0;
        check("R7 half period 12", gap_bad, 0);
        check("R7 edges at 12", n_edges, 6);
        rd(5'h08, v);
        wr(5'h00, 16'd0); exp_gap = 65536;
        wr(5'h0C, ctlw(1, 1, 0, 0, 1, 1, 1, 1, 1));
        mon_start(); wr(5'h04, 16'h0001); wait_irq(); mon_on = 1'b0;
        check("R7 zero divisor gap", 32'(gap_last / 4), 65536);
        check("R7 zero divisor edges", n_edges, 2);
        rd(5'h08, v); check("R7 zero divisor data", v, 16'h0001);

        summary();
    end
endmodule